// File: doc/BRIEF.md
# Instrument Status Reporting Register Set

This block keeps the status reporting state of a programmable instrument. A sticky event register catches single-cycle event pulses (power-on, query error and six general events) and holds each caught bit until software clears it. An event enable mask decides which held events raise the event summary bit of a live status byte. The status byte also carries an operation summary bit, taken from a level-valued operation event vector, and a master summary bit, taken from the status byte through a second enable mask.

Software reaches the block through a one-cycle access port: each access names an operation (read events with clear, write the event mask, write the status mask, read the status byte, clear status). The port applies no back-pressure. Any cycle with `acc_valid` high is accepted in that cycle, so there is no ready signal. Every read produces exactly one response, with `rsp_valid` high for one cycle, on the cycle after the access. Writes and clears produce no response. The status byte is also driven live on `status_byte`.

Top module: `instr_status_regs`

## Requirements
- R1: A set event bit stays set through any number of cycles without a clear access, and bits never set stay 0.
- R2: `ev_pulse[7]` is the power-on event and sets event bit 7. `ev_pulse[2]` is the query-error event and sets event bit 2. Each other pulse bit sets the event bit of the same index.
- R3: Status byte bit 5 is high exactly when the event register ANDed with the event enable mask is nonzero. With a zero mask it is low even when events are held.
- R4: Status byte bit 7 is high exactly when some bit of `op_status` is high, and it follows that input in the same cycle without latching.
- R5: Status byte bit 6 is high exactly when bits 7 and 5..0 of the status byte, ANDed with the status enable mask, are nonzero. Bit 6 of that mask has no effect.
- R6: Status byte bits 4..0 always read 0.
- R7: Op code 0 reads the event register. The response carries the value held before the access, and the register is cleared afterwards.
- R8: Op code 4 clears the event register only. Both masks (op code 1 writes the event mask and op code 2 writes the status mask, each from `acc_wdata`) keep their values.
- R9: An event pulse in the same cycle as an event read or a clear leaves its bit set afterwards. The read response does not include that new pulse.
- R10: Op code 3 reads the status byte as it is in the access cycle, and the status byte is unchanged by the read.
- R11: After reset the event register, both masks and the status byte are 0, and no response is pending.
- R12: `rsp_valid` is high on the cycle after a read access (op code 0 or 3) and at no other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_pulse | input | 8 | Single-cycle event pulses, one per event bit |
| op_status | input | OPW | Operation-status event vector, level |
| acc_valid | input | 1 | Access strobe, accepted every cycle |
| acc_op | input | 3 | Access operation code |
| acc_wdata | input | 8 | Mask write data |
| rsp_valid | output | 1 | Read response valid, one cycle |
| rsp_data | output | 8 | Read response value |
| status_byte | output | 8 | Live status byte |

## Verification
The bench drives events in the same cycle as a read and as a clear. A design that let the clear win would lose the event, and one that returned the post-update value would report it early. It loads a status mask with only bit 6 set, which catches a master summary that feeds back on itself. It also sets events while the event mask is zero, which catches a summary that ignores the mask. After a clear it checks that a new event again raises the summary bit, which a design that also cleared the masks would fail. Reads of the status byte are repeated, and write operations must give no response.

// File: rtl/instr_status_pkg.sv
package instr_status_pkg;
  localparam int DW     = 8;
  localparam int SB_OSE = 7;
  localparam int SB_MSS = 6;
  localparam int SB_ESB = 5;
  localparam int EV_PON = 7;
  localparam int EV_QYE = 2;

  typedef enum logic [2:0] {
    OP_RD_EVT = 3'd0,
    OP_WR_EEN = 3'd1,
    OP_WR_SEN = 3'd2,
    OP_RD_SB  = 3'd3,
    OP_CLEAR  = 3'd4
  } acc_op_e;
endpackage

// File: rtl/stat_evt_latch.sv
module stat_evt_latch #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic         clr_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q;

  // a pulse in the clear cycle survives: the set term is ORed after the clear
  always_ff @(posedge clk) begin
    if (!rst_n) q <= '0;
    else        q <= (clr_i ? '0 : q) | set_i;
  end

  assign q_o = q;
endmodule

// File: rtl/stat_mask_reg.sv
module stat_mask_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q;

  always_ff @(posedge clk) begin
    if (!rst_n)    q <= '0;
    else if (we_i) q <= d_i;
  end

  assign q_o = q;
endmodule

// File: rtl/stat_summary.sv
module stat_summary
  import instr_status_pkg::*;
#(
  parameter int OPW = 16
) (
  input  logic [DW-1:0]  evt_i,
  input  logic [DW-1:0]  een_i,
  input  logic [DW-1:0]  sen_i,
  input  logic [OPW-1:0] op_i,
  output logic [DW-1:0]  sb_o
);
  logic          ose;
  logic          esb;
  logic          mss;
  logic [DW-1:0] pre;

  always_comb begin
    ose = |op_i;
    esb = |(evt_i & een_i);
    pre = '0;
    pre[SB_OSE] = ose;
    pre[SB_ESB] = esb;
    // pre[SB_MSS] is always 0, so mask bit 6 cannot feed back
    mss = |(pre & sen_i);
    sb_o = pre;
    sb_o[SB_MSS] = mss;
  end
endmodule

// File: rtl/instr_status_regs.sv
module instr_status_regs
  import instr_status_pkg::*;
#(
  parameter int OPW = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [7:0]     ev_pulse,
  input  logic [OPW-1:0] op_status,
  input  logic           acc_valid,
  input  logic [2:0]     acc_op,
  input  logic [7:0]     acc_wdata,
  output logic           rsp_valid,
  output logic [7:0]     rsp_data,
  output logic [7:0]     status_byte
);
  logic [DW-1:0] evt_q;
  logic [DW-1:0] een_q;
  logic [DW-1:0] sen_q;
  logic [DW-1:0] sb;
  logic          do_rd_evt;
  logic          do_rd_sb;
  logic          do_clr;
  logic          we_een;
  logic          we_sen;
  logic          rsp_v_q;
  logic [DW-1:0] rsp_d_q;

  always_comb begin
    do_rd_evt = acc_valid && (acc_op == OP_RD_EVT);
    do_rd_sb  = acc_valid && (acc_op == OP_RD_SB);
    do_clr    = acc_valid && (acc_op == OP_CLEAR);
    we_een    = acc_valid && (acc_op == OP_WR_EEN);
    we_sen    = acc_valid && (acc_op == OP_WR_SEN);
  end

  stat_evt_latch #(.W(DW)) u_evt (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i (ev_pulse),
    .clr_i (do_rd_evt | do_clr),
    .q_o   (evt_q)
  );

  stat_mask_reg #(.W(DW)) u_een (
    .clk   (clk),
    .rst_n (rst_n),
    .we_i  (we_een),
    .d_i   (acc_wdata),
    .q_o   (een_q)
  );

  stat_mask_reg #(.W(DW)) u_sen (
    .clk   (clk),
    .rst_n (rst_n),
    .we_i  (we_sen),
    .d_i   (acc_wdata),
    .q_o   (sen_q)
  );

  stat_summary #(.OPW(OPW)) u_sum (
    .evt_i (evt_q),
    .een_i (een_q),
    .sen_i (sen_q),
    .op_i  (op_status),
    .sb_o  (sb)
  );

  // response captures pre-clear values in the access cycle
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_v_q <= 1'b0;
      rsp_d_q <= '0;
    end else begin
      rsp_v_q <= do_rd_evt | do_rd_sb;
      if (do_rd_evt)     rsp_d_q <= evt_q;
      else if (do_rd_sb) rsp_d_q <= sb;
    end
  end

  assign rsp_valid   = rsp_v_q;
  assign rsp_data    = rsp_d_q;
  assign status_byte = sb;
endmodule

// File: rtl/instr_status_regs_chk.sv
module instr_status_regs_chk #(
  parameter int OPW = 16
) (
  input logic           clk,
  input logic           rst_n,
  input logic [7:0]     ev_pulse,
  input logic [OPW-1:0] op_status,
  input logic           acc_valid,
  input logic [2:0]     acc_op,
  input logic           rsp_valid,
  input logic [7:0]     status_byte,
  input logic [7:0]     evt_q,
  input logic [7:0]     een_q,
  input logic [7:0]     sen_q
);
  logic rd_acc;
  logic clr_acc;
  assign rd_acc  = acc_valid && (acc_op == 3'd0 || acc_op == 3'd3);
  assign clr_acc = acc_valid && (acc_op == 3'd0 || acc_op == 3'd4);

  // R1
  evt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_acc |=> ((evt_q & $past(evt_q)) == $past(evt_q)));

  // R3
  esb_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (een_q == 8'h00) |-> !status_byte[5]);

  // R4
  ose_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
    status_byte[7] == (|op_status));

  // R6
  unused_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    status_byte[4:0] == 5'd0);

  // R7
  rd_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_op == 3'd0) |=> (evt_q == $past(ev_pulse)));

  // R8
  clr_keeps_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_op == 3'd4) |=> (een_q == $past(een_q) && sen_q == $past(sen_q)));

  // R12
  rsp_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid == $past(rd_acc));

  for (genvar i = 0; i < 8; i++) begin : g_ev
    // R9
    pulse_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ev_pulse[i] |=> evt_q[i]);
  end
endmodule

bind instr_status_regs instr_status_regs_chk #(.OPW(OPW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .ev_pulse    (ev_pulse),
  .op_status   (op_status),
  .acc_valid   (acc_valid),
  .acc_op      (acc_op),
  .rsp_valid   (rsp_valid),
  .status_byte (status_byte),
  .evt_q       (evt_q),
  .een_q       (een_q),
  .sen_q       (sen_q)
);

// File: tb/instr_status_regs_test.sv
module instr_status_regs_test;
  localparam int OPW = 16;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [7:0]     ev_pulse = '0;
  logic [OPW-1:0] op_status = '0;
  logic           acc_valid = 1'b0;
  logic [2:0]     acc_op = '0;
  logic [7:0]     acc_wdata = '0;
  logic           rsp_valid;
  logic [7:0]     rsp_data;
  logic [7:0]     status_byte;

  instr_status_regs #(.OPW(OPW)) uut (
    .clk(clk), .rst_n(rst_n), .ev_pulse(ev_pulse), .op_status(op_status),
    .acc_valid(acc_valid), .acc_op(acc_op), .acc_wdata(acc_wdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .status_byte(status_byte)
  );

  always #10 clk = ~clk;

  typedef struct { logic [7:0] data; string tag; } exp_t;
  exp_t exp_q[$];

  int checks = 0;
  int errors = 0;
  logic [7:0] m_evt = '0, m_een = '0, m_sen = '0;

  function automatic logic [7:0] sb_model(logic [7:0] ev, logic [7:0] ee,
                                          logic [7:0] se, logic [OPW-1:0] op);
    logic [7:0] v;
    v = '0;
    v[7] = |op;
    v[5] = |(ev & ee);
    v[6] = |({v[7], 1'b0, v[5], 5'b0} & se);
    return v;
  endfunction

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  // driver: one access (or idle) plus optional pulses, model updated
  task automatic step(bit v, logic [2:0] op, logic [7:0] wd, logic [7:0] pulse, string tag);
    exp_t e;
    @(negedge clk);
    acc_valid = v; acc_op = op; acc_wdata = wd; ev_pulse = pulse;
    if (v && op == 3'd0) begin e.data = m_evt; e.tag = tag; exp_q.push_back(e); end
    if (v && op == 3'd3) begin
      e.data = sb_model(m_evt, m_een, m_sen, op_status); e.tag = tag; exp_q.push_back(e);
    end
    if (v && op == 3'd1) m_een = wd;
    if (v && op == 3'd2) m_sen = wd;
    m_evt = ((v && (op == 3'd0 || op == 3'd4)) ? 8'h00 : m_evt) | pulse;
    @(negedge clk);
    acc_valid = 1'b0; ev_pulse = '0;
  endtask

  task automatic chk_sb(string tag);
    #1 check(tag, status_byte, sb_model(m_evt, m_een, m_sen, op_status));
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R12: actual=unexpected response %02h expected=none", rsp_data);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check(e.tag, rsp_data, e.data);
      end
    end
  end

  initial begin
    #(20 * 20000);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk_sb("R11 status byte after reset");
    step(1, 3'd0, 0, 0, "R11 event reg after reset");
    // R2 power-on and query error bits, R1 sticky
    step(0, 0, 0, 8'h80, "idle");
    step(0, 0, 0, 8'h04, "idle");
    repeat (3) step(0, 0, 0, 0, "idle");
    step(1, 3'd0, 0, 0, "R2 R1 held power-on and query-error");
    step(1, 3'd0, 0, 0, "R7 cleared after read");
    // R3 zero mask
    step(0, 0, 0, 8'h84, "idle");
    chk_sb("R3 zero mask hides events");
    step(1, 3'd1, 8'h04, 0, "wr een");
    chk_sb("R3 enabled query error sets bit 5");
    step(1, 3'd1, 8'h03, 0, "wr een");
    chk_sb("R3 mask without held bits");
    // R5 master summary
    step(1, 3'd1, 8'h80, 0, "wr een");
    step(1, 3'd2, 8'h40, 0, "wr sen");
    chk_sb("R5 mask bit 6 ignored");
    step(1, 3'd2, 8'h20, 0, "wr sen");
    chk_sb("R5 master from bit 5");
    // R4 operation summary
    op_status = 16'h0100;
    chk_sb("R4 op vector sets bit 7");
    step(1, 3'd2, 8'h80, 0, "wr sen");
    chk_sb("R5 master from bit 7");
    // R10 repeated status reads
    step(1, 3'd3, 0, 0, "R10 first status read");
    step(1, 3'd3, 0, 0, "R10 second status read");
    chk_sb("R10 status unchanged by read");
    op_status = '0;
    chk_sb("R4 bit 7 drops live");
    check("R6 low bits zero", {3'b0, status_byte[4:0]}, 8'h00);
    // R8 clear keeps masks
    step(1, 3'd4, 0, 0, "clear");
    chk_sb("R8 clear empties events");
    step(0, 0, 0, 8'h80, "idle");
    chk_sb("R8 mask survives clear");
    // R9 pulse with read and with clear
    step(1, 3'd0, 0, 8'h02, "R9 read excludes same-cycle pulse");
    step(1, 3'd0, 0, 0, "R9 pulse kept after read");
    step(1, 3'd4, 0, 8'h10, "R9 pulse with clear");
    step(1, 3'd0, 0, 0, "R9 pulse kept after clear");
    // R1 general bits
    step(0, 0, 0, 8'h41, "idle");
    step(0, 0, 0, 0, "idle");
    step(1, 3'd0, 0, 0, "R1 general events held");
    repeat (3) @(negedge clk);
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R12: actual=%0d missing responses expected=0", exp_q.size());
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule